// File: doc/BRIEF.md
# Real-Time Clock Status Flag Register

This block holds the 18-bit status word of a real-time clock. It gathers single-cycle event pulses from the clock's alarm comparators, wakeup counter, timestamp and tamper logic, shift and calibration engines. It keeps each event as a sticky flag until software clears it by writing 0. It also follows a few level inputs (alarm and wakeup enables, shadow bypass, nonzero year) and runs the handshake that takes the calendar into and out of initialization.

Software reaches the register through a plain bus: a one-cycle write strobe with data, and a read word that is always present. The event field in bits 8 to 13 may be cleared at any time. Every other writable bit changes only while the unlock input is high during the write. Bit positions are fixed because driver code decodes them.

Top module: `rtcStatusReg`

## Requirements
- R1: After reset the read word is 0x00007: bits 0, 1 and 2 (alarm A, alarm B and wakeup write-ok) are 1 and all other bits are 0.
- R2: A one-cycle pulse on an event input sets its flag on the next clock edge, and the flag stays set: alarm A bit 8, alarm B bit 9, wakeup bit 10, timestamp bit 11, tamper inputs 0..2 bits 13..15, internal timestamp bit 17.
- R3: Writing 0 to a set event flag clears it. Writing 1 to it leaves it unchanged.
- R4: When a hardware set and a software clear reach the same event flag in the same cycle, the flag ends up set.
- R5: Bit 12 (timestamp overflow) sets when a timestamp pulse arrives while bit 11 is already 1. It is cleared by writing 0.
- R6: Without unlock, a write affects only bits 8 to 13. Bits 5, 7, 14, 15 and 17 change from a write only while unlock is 1.
- R7: Bit 3 (shift pending) sets on a shift-request pulse and clears on a shift-done pulse. A write never changes it.
- R8: Bit 5 (synchronized) sets on a shadow-copy pulse. It is forced to 0 in the cycle after bit 7, bit 3 or the bypass input is 1. An unlocked write of 0 clears it.
- R9: Bit 7 (init request) follows an unlocked write. Bit 6 (init ready) becomes 1 two clock edges after bit 7 is written to 1, and drops on the same edge at which bit 7 is written to 0.
- R10: Bit 2 (wakeup write-ok) equals the inverse of the wakeup enable input delayed by two clock edges.
- R11: Bits 0 and 1 are 1 one edge after their alarm enable is low while bit 7 is 0. Otherwise they are 0.
- R12: Bit 16 (recalibration pending) sets on a calibration-write pulse and clears on a calibration-applied pulse.
- R13: Bit 4 (calendar initialized) follows the nonzero-year input one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One-cycle write strobe |
| wrData | input | 18 | Write data |
| unlock | input | 1 | Write-protection release, sampled with wrEn |
| rdData | output | 18 | Current status word |
| alarmAHit | input | 1 | Alarm A match pulse |
| alarmBHit | input | 1 | Alarm B match pulse |
| wakeHit | input | 1 | Wakeup counter reached zero |
| stampHit | input | 1 | Timestamp event pulse |
| intStampHit | input | 1 | Internal timestamp event pulse |
| tamperHit | input | 3 | Tamper event pulses, one per input |
| shiftReq | input | 1 | Shift operation requested |
| shiftDone | input | 1 | Shift operation applied |
| calWrite | input | 1 | Calibration register written |
| calApplied | input | 1 | New calibration took effect |
| shadowCopy | input | 1 | Calendar copied to shadow registers |
| alarmAEn | input | 1 | Alarm A enable level |
| alarmBEn | input | 1 | Alarm B enable level |
| wakeEn | input | 1 | Wakeup timer enable level |
| bypassMode | input | 1 | Shadow-register bypass level |
| yearNonzero | input | 1 | Year field is nonzero |

## Verification
The assertions assume that the request and completion pulses of a pair (shift request and done, calibration write and applied) never arrive in the same cycle. They also assume that event inputs are single-cycle pulses sampled on the rising edge. The stimulus keeps to this by driving every input at the falling edge, raising each pulse for one cycle, and never overlapping the two halves of a pair. Writes that are not meant to touch bit 7 always carry 0 there, so the init handshake starts only in the scenario that tests it.

// File: rtl/rtcStatusPkg.sv
package rtcStatusPkg;
  localparam int STATUS_W = 18;

  localparam int B_ALA_OK  = 0;
  localparam int B_ALB_OK  = 1;
  localparam int B_WAKE_OK = 2;
  localparam int B_SHIFT   = 3;
  localparam int B_INITD   = 4;
  localparam int B_SYNC    = 5;
  localparam int B_READY   = 6;
  localparam int B_INITREQ = 7;
  localparam int B_ALA     = 8;
  localparam int B_ALB     = 9;
  localparam int B_WAKE    = 10;
  localparam int B_STAMP   = 11;
  localparam int B_OVF     = 12;
  localparam int B_TAMP0   = 13;
  localparam int N_TAMP    = 3;
  localparam int B_RECAL   = 16;
  localparam int B_ISTAMP  = 17;

  // bits writable with the unlock input low
  localparam logic [STATUS_W-1:0] OPEN_MASK  = 18'h03F00;
  // bits a write may touch at all
  localparam logic [STATUS_W-1:0] WR_MASK    = 18'h2FFA0;
  // bits cleared by writing 0
  localparam logic [STATUS_W-1:0] CLR_MASK   = 18'h2FF20;
  // sticky hardware event bits
  localparam logic [STATUS_W-1:0] EVENT_MASK = 18'h2FF00;

  typedef struct packed {
    logic [STATUS_W-1:0] clearMask;
    logic                initWrite;
    logic                initValue;
    logic                initReady;
    logic                wakeOk;
  } ctrlStrobe_t;
endpackage

// File: rtl/rtcStatusCtrl.sv
module rtcStatusCtrl
  import rtcStatusPkg::*;
#(
  parameter int INIT_DELAY  = 2,
  parameter int WAKE_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [STATUS_W-1:0] wrData,
  input  logic                unlock,
  input  logic                wakeEn,
  input  logic                initReqQ,
  output ctrlStrobe_t         strobe
);
  logic [STATUS_W-1:0] allowMask;
  logic                initReqNext;
  logic [INIT_DELAY-1:0]  readyPipe;
  logic [WAKE_STAGES-1:0] wakePipe;

  always_comb begin
    allowMask = unlock ? WR_MASK : OPEN_MASK;
    strobe.clearMask = wrEn ? (allowMask & CLR_MASK & ~wrData) : '0;
    strobe.initWrite = wrEn && unlock;
    strobe.initValue = wrData[B_INITREQ];
    initReqNext = strobe.initWrite ? strobe.initValue : initReqQ;
    strobe.initReady = readyPipe[INIT_DELAY-1];
    strobe.wakeOk    = wakePipe[WAKE_STAGES-1];
  end

  // init-ready delay line, flushed the moment the request drops
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyPipe <= '0;
    end else begin
      readyPipe[0] <= initReqNext && initReqQ;
      for (int i = 1; i < INIT_DELAY; i++) begin
        readyPipe[i] <= readyPipe[i-1] && initReqNext;
      end
    end
  end

  // wakeup write-ok follows the inverted enable through a short pipe
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wakePipe <= '1;
    end else begin
      wakePipe[0] <= !wakeEn;
      for (int i = 1; i < WAKE_STAGES; i++) begin
        wakePipe[i] <= wakePipe[i-1];
      end
    end
  end

  p_protect_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !unlock) |-> (((strobe.clearMask & ~OPEN_MASK) == '0) && !strobe.initWrite));

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.initWrite && !strobe.initValue) |=> !strobe.initReady);
endmodule

// File: rtl/rtcStatusData.sv
module rtcStatusData
  import rtcStatusPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic                alarmAHit,
  input  logic                alarmBHit,
  input  logic                wakeHit,
  input  logic                stampHit,
  input  logic                intStampHit,
  input  logic [N_TAMP-1:0]   tamperHit,
  input  logic                shiftReq,
  input  logic                shiftDone,
  input  logic                calWrite,
  input  logic                calApplied,
  input  logic                shadowCopy,
  input  logic                alarmAEn,
  input  logic                alarmBEn,
  input  logic                bypassMode,
  input  logic                yearNonzero,
  output logic                initReqQ,
  output logic [STATUS_W-1:0] rdData
);
  logic [STATUS_W-1:0] flagsQ, flagsNext, hwSet, liveBits;

  always_comb begin
    hwSet = '0;
    hwSet[B_ALA]    = alarmAHit;
    hwSet[B_ALB]    = alarmBHit;
    hwSet[B_WAKE]   = wakeHit;
    hwSet[B_STAMP]  = stampHit;
    hwSet[B_OVF]    = stampHit && flagsQ[B_STAMP];
    hwSet[B_ISTAMP] = intStampHit;
    for (int t = 0; t < N_TAMP; t++) hwSet[B_TAMP0+t] = tamperHit[t];

    flagsNext = (hwSet | (flagsQ & ~strobe.clearMask)) & EVENT_MASK;

    flagsNext[B_ALA_OK] = !alarmAEn && !flagsQ[B_INITREQ];
    flagsNext[B_ALB_OK] = !alarmBEn && !flagsQ[B_INITREQ];
    flagsNext[B_INITD]  = yearNonzero;

    if (shiftReq)       flagsNext[B_SHIFT] = 1'b1;
    else if (shiftDone) flagsNext[B_SHIFT] = 1'b0;
    else                flagsNext[B_SHIFT] = flagsQ[B_SHIFT];

    if (calWrite)        flagsNext[B_RECAL] = 1'b1;
    else if (calApplied) flagsNext[B_RECAL] = 1'b0;
    else                 flagsNext[B_RECAL] = flagsQ[B_RECAL];

    if (flagsQ[B_INITREQ] || flagsQ[B_SHIFT] || bypassMode) flagsNext[B_SYNC] = 1'b0;
    else if (shadowCopy)                flagsNext[B_SYNC] = 1'b1;
    else if (strobe.clearMask[B_SYNC])  flagsNext[B_SYNC] = 1'b0;
    else                                flagsNext[B_SYNC] = flagsQ[B_SYNC];

    flagsNext[B_INITREQ] = strobe.initWrite ? strobe.initValue : flagsQ[B_INITREQ];
  end

  always_ff @(posedge clk) begin
    if (!rstN) flagsQ <= 18'h00003;
    else       flagsQ <= flagsNext;
  end

  always_comb begin
    liveBits = '0;
    liveBits[B_WAKE_OK] = strobe.wakeOk;
    liveBits[B_READY]   = strobe.initReady;
    rdData   = flagsQ | liveBits;
    initReqQ = flagsQ[B_INITREQ];
  end

  p_event_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    alarmAHit |=> rdData[B_ALA]);

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rstN)
    (intStampHit && strobe.clearMask[B_ISTAMP]) |=> rdData[B_ISTAMP]);

  p_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stampHit && rdData[B_STAMP]) |=> rdData[B_OVF]);

  p_shift_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftReq && !shiftDone) |=> $stable(rdData[B_SHIFT]));

  p_sync_force_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[B_INITREQ] || rdData[B_SHIFT] || bypassMode) |=> !rdData[B_SYNC]);

  p_recal_set_r12: assert property (@(posedge clk) disable iff (!rstN)
    calWrite |=> rdData[B_RECAL]);
endmodule

// File: rtl/rtcStatusReg.sv
module rtcStatusReg
  import rtcStatusPkg::*;
#(
  parameter int INIT_DELAY  = 2,
  parameter int WAKE_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [17:0]       wrData,
  input  logic              unlock,
  output logic [17:0]       rdData,
  input  logic              alarmAHit,
  input  logic              alarmBHit,
  input  logic              wakeHit,
  input  logic              stampHit,
  input  logic              intStampHit,
  input  logic [2:0]        tamperHit,
  input  logic              shiftReq,
  input  logic              shiftDone,
  input  logic              calWrite,
  input  logic              calApplied,
  input  logic              shadowCopy,
  input  logic              alarmAEn,
  input  logic              alarmBEn,
  input  logic              wakeEn,
  input  logic              bypassMode,
  input  logic              yearNonzero
);
  ctrlStrobe_t strobe;
  logic        initReqQ;

  rtcStatusCtrl #(.INIT_DELAY(INIT_DELAY), .WAKE_STAGES(WAKE_STAGES)) ctrlInst (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .unlock(unlock),
    .wakeEn(wakeEn), .initReqQ(initReqQ), .strobe(strobe)
  );

  rtcStatusData dataInst (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .alarmAHit(alarmAHit), .alarmBHit(alarmBHit), .wakeHit(wakeHit),
    .stampHit(stampHit), .intStampHit(intStampHit), .tamperHit(tamperHit),
    .shiftReq(shiftReq), .shiftDone(shiftDone), .calWrite(calWrite),
    .calApplied(calApplied), .shadowCopy(shadowCopy), .alarmAEn(alarmAEn),
    .alarmBEn(alarmBEn), .bypassMode(bypassMode), .yearNonzero(yearNonzero),
    .initReqQ(initReqQ), .rdData(rdData)
  );
endmodule

// File: tb/rtcStatusReg_test.sv
`timescale 1ns/1ps
module rtcStatusReg_test;
  logic clk = 0, rstN = 0, wrEn = 0, unlock = 0;
  logic [17:0] wrData = '0;
  logic [17:0] rdData;
  logic alarmAHit = 0, alarmBHit = 0, wakeHit = 0, stampHit = 0, intStampHit = 0;
  logic [2:0] tamperHit = '0;
  logic shiftReq = 0, shiftDone = 0, calWrite = 0, calApplied = 0, shadowCopy = 0;
  logic alarmAEn = 0, alarmBEn = 0, wakeEn = 0, bypassMode = 0, yearNonzero = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  rtcStatusReg uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .unlock(unlock),
    .rdData(rdData), .alarmAHit(alarmAHit), .alarmBHit(alarmBHit),
    .wakeHit(wakeHit), .stampHit(stampHit), .intStampHit(intStampHit),
    .tamperHit(tamperHit), .shiftReq(shiftReq), .shiftDone(shiftDone),
    .calWrite(calWrite), .calApplied(calApplied), .shadowCopy(shadowCopy),
    .alarmAEn(alarmAEn), .alarmBEn(alarmBEn), .wakeEn(wakeEn),
    .bypassMode(bypassMode), .yearNonzero(yearNonzero)
  );

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input int b, input logic exp);
    check(tag, {17'd0, rdData[b]}, {17'd0, exp});
  endtask

  // writes take effect at the edge inside this task; result readable on return
  task automatic regWrite(input logic [17:0] d, input logic u);
    @(negedge clk); wrData = d; wrEn = 1; unlock = u;
    @(negedge clk); wrEn = 0; unlock = 0; wrData = '0;
  endtask

  function automatic logic [17:0] clearOne(input int b);
    return ~(18'd1 << b) & ~18'h00080;
  endfunction

  task automatic testReset();
    check("R1 reset word", rdData, 18'h00007);
  endtask

  task automatic testEvents();
    @(negedge clk); alarmAHit = 1; alarmBHit = 1; wakeHit = 1; tamperHit = 3'b111; intStampHit = 1;
    @(negedge clk); alarmAHit = 0; alarmBHit = 0; wakeHit = 0; tamperHit = 0; intStampHit = 0;
    check("R2 event bits set", rdData & 18'h2E700, 18'h2E700);
    repeat (3) @(negedge clk);
    check("R2 event bits sticky", rdData & 18'h2E700, 18'h2E700);
    regWrite(18'h3FF7F, 1'b0);
    check("R3 write ones keeps flags", rdData & 18'h2E700, 18'h2E700);
    regWrite(clearOne(8), 1'b0);
    checkBit("R3 alarm A cleared by 0", 8, 1'b0);
    checkBit("R3 alarm B untouched", 9, 1'b1);
    regWrite(clearOne(9) & clearOne(10), 1'b0);
    check("R3 alarm B and wakeup cleared", rdData & 18'h00600, 18'h0);
  endtask

  task automatic testProtect();
    regWrite(clearOne(14) & clearOne(15) & clearOne(17), 1'b0);
    check("R6 locked bits 14,15,17 kept", rdData & 18'h2C000, 18'h2C000);
    regWrite(clearOne(13), 1'b0);
    checkBit("R6 open bit 13 cleared w/o unlock", 13, 1'b0);
    regWrite(clearOne(14) & clearOne(15) & clearOne(17), 1'b1);
    check("R6 unlocked clears 14,15,17", rdData & 18'h2C000, 18'h0);
  endtask

  task automatic testSetWins();
    @(negedge clk); intStampHit = 1; wrEn = 1; unlock = 1; wrData = clearOne(17);
    @(negedge clk); intStampHit = 0; wrEn = 0; unlock = 0; wrData = '0;
    checkBit("R4 set beats clear", 17, 1'b1);
    regWrite(clearOne(17), 1'b1);
    checkBit("R4 later clear works", 17, 1'b0);
  endtask

  task automatic testOverflow();
    @(negedge clk); stampHit = 1;
    @(negedge clk); stampHit = 0;
    check("R5 first stamp no overflow", rdData & 18'h01800, 18'h00800);
    @(negedge clk); stampHit = 1;
    @(negedge clk); stampHit = 0;
    check("R5 second stamp overflow", rdData & 18'h01800, 18'h01800);
    regWrite(clearOne(11), 1'b0);
    regWrite(clearOne(12), 1'b0);
    check("R5 both cleared", rdData & 18'h01800, 18'h0);
  endtask

  task automatic testShift();
    @(negedge clk); shiftReq = 1;
    @(negedge clk); shiftReq = 0;
    checkBit("R7 shift pending set", 3, 1'b1);
    regWrite(18'h00000, 1'b1);
    checkBit("R7 write 0 ignored", 3, 1'b1);
    @(negedge clk); shiftDone = 1;
    @(negedge clk); shiftDone = 0;
    checkBit("R7 shift done clears", 3, 1'b0);
    regWrite(18'h00008, 1'b1);
    checkBit("R7 write 1 ignored", 3, 1'b0);
  endtask

  task automatic testSync();
    @(negedge clk); shadowCopy = 1;
    @(negedge clk); shadowCopy = 0;
    checkBit("R8 copy sets sync", 5, 1'b1);
    regWrite(clearOne(5), 1'b0);
    checkBit("R8 locked write keeps sync", 5, 1'b1);
    regWrite(clearOne(5), 1'b1);
    checkBit("R8 unlocked write 0 clears sync", 5, 1'b0);
    @(negedge clk); shadowCopy = 1;
    @(negedge clk); shadowCopy = 0; bypassMode = 1;
    checkBit("R8 sync set again", 5, 1'b1);
    @(negedge clk); bypassMode = 0;
    checkBit("R8 bypass forces clear", 5, 1'b0);
    @(negedge clk); shiftReq = 1;
    @(negedge clk); shiftReq = 0; shadowCopy = 1;
    @(negedge clk); shadowCopy = 0;
    checkBit("R8 shift pending blocks copy", 5, 1'b0);
    @(negedge clk); shiftDone = 1;
    @(negedge clk); shiftDone = 0;
  endtask

  task automatic testInit();
    regWrite(18'h3FFFF, 1'b1);
    check("R9 request set, ready low", rdData & 18'h000C0, 18'h00080);
    check("R11 write-ok still high", rdData & 18'h00003, 18'h00003);
    @(negedge clk);
    checkBit("R9 ready after 1 edge", 6, 1'b0);
    check("R11 init clears write-ok", rdData & 18'h00003, 18'h0);
    @(negedge clk);
    checkBit("R9 ready after 2 edges", 6, 1'b1);
    @(negedge clk); shadowCopy = 1;
    @(negedge clk); shadowCopy = 0;
    checkBit("R8 init blocks copy", 5, 1'b0);
    regWrite(18'h3FF7F, 1'b1);
    check("R9 request and ready drop together", rdData & 18'h000C0, 18'h0);
    @(negedge clk);
    check("R11 write-ok back", rdData & 18'h00003, 18'h00003);
  endtask

  task automatic testWake();
    @(negedge clk); wakeEn = 1;
    @(negedge clk);
    checkBit("R10 wake ok after 1 edge", 2, 1'b1);
    @(negedge clk);
    checkBit("R10 wake ok after 2 edges", 2, 1'b0);
    wakeEn = 0;
    @(negedge clk);
    checkBit("R10 still low after 1 edge", 2, 1'b0);
    @(negedge clk);
    checkBit("R10 high after 2 edges", 2, 1'b1);
  endtask

  task automatic testAlarmOk();
    @(negedge clk); alarmAEn = 1;
    @(negedge clk);
    check("R11 alarm A enable", rdData & 18'h00003, 18'h00002);
    alarmBEn = 1; alarmAEn = 0;
    @(negedge clk);
    check("R11 alarm B enable", rdData & 18'h00003, 18'h00001);
    alarmBEn = 0;
    @(negedge clk);
  endtask

  task automatic testRecal();
    @(negedge clk); calWrite = 1;
    @(negedge clk); calWrite = 0;
    checkBit("R12 recal pending", 16, 1'b1);
    @(negedge clk); calApplied = 1;
    @(negedge clk); calApplied = 0;
    checkBit("R12 recal done", 16, 1'b0);
  endtask

  task automatic testYear();
    @(negedge clk); yearNonzero = 1;
    @(negedge clk);
    checkBit("R13 initialized set", 4, 1'b1);
    yearNonzero = 0;
    @(negedge clk);
    checkBit("R13 initialized clear", 4, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testEvents();
    testProtect();
    testSetWins();
    testOverflow();
    testShift();
    testSync();
    testInit();
    testWake();
    testAlarmOk();
    testRecal();
    testYear();
    check("final event field clear", rdData & 18'h2FF00, 18'h0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule